// File: doc/BRIEF.md
# Shared-Unit Handshake Combiner

This block lets several request/acknowledge channels on the controller side share a single datapath unit. Every channel uses a four-phase handshake. The unit also sees one four-phase handshake. The block forwards a channel's request to the unit and steers the unit's acknowledge back to that channel. Two uses of the unit within one instruction therefore become separate, non-overlapping unit handshakes.

A build-time parameter selects one of two ways of combining the channels:

- **Merge:** the caller guarantees that requests never overlap, so they are simply combined.
- **Arbiter:** requests may overlap. A clocked mutual-exclusion grant in front of the merge admits one channel at a time. When several channels ask in the same cycle, the lowest index goes first.

Each channel passes through a decouple stage. The unit completes its handshake and returns to zero on its own. The controller, meanwhile, may keep its request high until the instruction ends. A channel's acknowledge rises only once the unit is idle again. It stays high until that channel's request falls, and the unit is free for other channels during that time.

Top module: `hs_share_unit`

## Requirements
- R1: After synchronous reset, every `ch_ack_o` bit and `unit_req_o` are low.
- R2: In merge mode, a request raised on an idle channel gives `unit_req_o` high after the next clock edge. Two channels being live together is a protocol error that an assertion reports.
- R3: `unit_req_o` falls on the edge after `unit_ack_i` is seen high. It stays low while the controller request is still held, and the channel's acknowledge stays low as long as `unit_ack_i` is high.
- R4: A channel's `ch_ack_o` bit rises on the edge after `unit_ack_i` is seen low following that channel's unit acknowledge.
- R5: A raised `ch_ack_o` bit stays high while its request is held. It falls on the edge after the request is seen low.
- R6: In arbiter mode, at most one channel owns the unit at any time. Requests raised in the same cycle are served in ascending channel index.
- R7: In arbiter mode, a request is granted on the first edge and drives `unit_req_o` on the second. The grant is kept until the owning channel's unit handshake has returned to zero. The next waiting channel then needs the same two edges.
- R8: A channel that has completed, and still holds its request, starts no further unit handshake.
- R9: A `unit_ack_i` pulse arriving while no channel owns the unit changes neither `ch_ack_o` nor `unit_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req_i | input | N_CH | Per-channel request from the controller |
| ch_ack_o | output | N_CH | Per-channel completion acknowledge |
| unit_req_o | output | 1 | Request to the shared unit |
| unit_ack_i | input | 1 | Acknowledge from the shared unit |

## Verification
Every result is due a fixed number of edges after the stimulus that causes it:

- In merge mode, the unit request appears one edge after the channel request. In arbiter mode it appears two edges after, because one edge goes to the grant and one to the channel state.
- The unit request drops one edge after the unit acknowledge rises.
- The channel acknowledge rises one edge after the unit acknowledge falls, and falls one edge after the request falls.

The bench drives inputs and samples outputs on the falling clock edge. It steps exactly the number of edges each result needs, so every check lands on the first cycle the value is due. In the intermediate cycles it also checks that the value has not yet changed. The arbiter is swept over every non-empty set of simultaneous requests on three channels, and the expected service order is derived from the request bits.

// File: rtl/hs_share_pkg.sv
package hs_share_pkg;

    typedef enum logic {
        SHARE_MERGE   = 1'b0,
        SHARE_ARBITER = 1'b1
    } share_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_UNIT     = 2'd1,
        CH_UNIT_RTZ = 2'd2,
        CH_HOLD     = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic pending;
        logic unit_req;
        logic active;
        logic release_done;
        logic ack;
    } ch_status_t;

endpackage

// File: rtl/hs_decouple_chan.sv
module hs_decouple_chan
    import hs_share_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       go_i,
    input  logic       unit_ack_i,
    output ch_status_t status_o
);

    ch_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CH_IDLE;
        end else begin
            unique case (st_q)
                CH_IDLE:     if (req_i && go_i) st_q <= CH_UNIT;
                CH_UNIT:     if (unit_ack_i)    st_q <= CH_UNIT_RTZ;
                CH_UNIT_RTZ: if (!unit_ack_i)   st_q <= CH_HOLD;
                CH_HOLD:     if (!req_i)        st_q <= CH_IDLE;
                default:                        st_q <= CH_IDLE;
            endcase
        end
    end

    always_comb begin
        status_o.pending      = (st_q == CH_IDLE) && req_i;
        status_o.unit_req     = (st_q == CH_UNIT);
        status_o.active       = (st_q == CH_UNIT) || (st_q == CH_UNIT_RTZ);
        status_o.release_done = (st_q == CH_UNIT_RTZ) && !unit_ack_i;
        status_o.ack          = (st_q == CH_HOLD);
    end

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        (status_o.ack && !req_i) |=> !status_o.ack); // R5
    AST_ACK_AFTER_RTZ: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o.ack) |-> !unit_ack_i); // R4
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
        (status_o.ack && req_i) |=> !status_o.unit_req); // R8

endmodule

// File: rtl/hs_grant_arbiter.sv
module hs_grant_arbiter #(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] pending_i,
    input  logic [N_CH-1:0] release_i,
    output logic [N_CH-1:0] grant_o
);

    localparam logic [N_CH-1:0] ONE = {{(N_CH-1){1'b0}}, 1'b1};

    logic [N_CH-1:0] grant_q;
    logic [N_CH-1:0] lowest;
    logic            grant_done;

    assign lowest     = pending_i & (~pending_i + ONE);
    assign grant_done = |(grant_q & release_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if (grant_done) begin
            grant_q <= '0;
        end else if ((grant_q == '0) && (|pending_i)) begin
            grant_q <= lowest;
        end
    end

    assign grant_o = grant_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q)); // R6
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        ((grant_q != '0) && !grant_done) |=> $stable(grant_q)); // R7

endmodule

// File: rtl/hs_unit_merge.sv
module hs_unit_merge #(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] ch_unit_req_i,
    input  logic [N_CH-1:0] ch_active_i,
    input  logic            unit_ack_i,
    output logic            unit_req_o,
    output logic [N_CH-1:0] ch_unit_ack_o
);

    assign unit_req_o    = |ch_unit_req_i;
    assign ch_unit_ack_o = ch_active_i & {N_CH{unit_ack_i}};

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $countones(ch_active_i) <= 1); // R6
    AST_UNIT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (unit_req_o && unit_ack_i) |=> !unit_req_o); // R3

endmodule

// File: rtl/hs_share_unit.sv
module hs_share_unit
    import hs_share_pkg::*;
#(
    parameter int          N_CH = 3,
    parameter share_mode_e MODE = SHARE_ARBITER
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] ch_req_i,
    output logic [N_CH-1:0] ch_ack_o,
    output logic            unit_req_o,
    input  logic            unit_ack_i
);

    ch_status_t      st [N_CH];
    logic [N_CH-1:0] pending;
    logic [N_CH-1:0] ch_unit_req;
    logic [N_CH-1:0] active;
    logic [N_CH-1:0] release_done;
    logic [N_CH-1:0] go;
    logic [N_CH-1:0] steered_ack;

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        hs_decouple_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .req_i      (ch_req_i[i]),
            .go_i       (go[i]),
            .unit_ack_i (steered_ack[i]),
            .status_o   (st[i])
        );
        assign pending[i]      = st[i].pending;
        assign ch_unit_req[i]  = st[i].unit_req;
        assign active[i]       = st[i].active;
        assign release_done[i] = st[i].release_done;
        assign ch_ack_o[i]     = st[i].ack;
    end

    if (MODE == SHARE_ARBITER) begin : g_arb
        hs_grant_arbiter #(.N_CH(N_CH)) u_arb (
            .clk       (clk),
            .rst       (rst),
            .pending_i (pending),
            .release_i (release_done),
            .grant_o   (go)
        );
    end else begin : g_merge
        assign go = '1;
        AST_MERGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            $countones(pending | active) <= 1); // R2
    end

    hs_unit_merge #(.N_CH(N_CH)) u_merge (
        .clk           (clk),
        .rst           (rst),
        .ch_unit_req_i (ch_unit_req),
        .ch_active_i   (active),
        .unit_ack_i    (unit_ack_i),
        .unit_req_o    (unit_req_o),
        .ch_unit_ack_o (steered_ack)
    );

endmodule

// File: tb/hs_share_unit_tb.sv
`timescale 1ns/1ps
module hs_share_unit_tb_top;
    import hs_share_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [2:0] a_req = '0;
    logic [2:0] a_ack;
    logic       a_ureq;
    logic       a_uack = 1'b0;
    logic [1:0] m_req = '0;
    logic [1:0] m_ack;
    logic       m_ureq;
    logic       m_uack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    hs_share_unit #(.N_CH(3), .MODE(SHARE_ARBITER)) dut_i (
        .clk(clk), .rst(rst), .ch_req_i(a_req), .ch_ack_o(a_ack),
        .unit_req_o(a_ureq), .unit_ack_i(a_uack));

    hs_share_unit #(.N_CH(2), .MODE(SHARE_MERGE)) dut_m (
        .clk(clk), .rst(rst), .ch_req_i(m_req), .ch_ack_o(m_ack),
        .unit_req_o(m_ureq), .unit_ack_i(m_uack));

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] done;
        repeat (3) step();
        chk("R1 arb ack", a_ack, 0);
        chk("R1 arb unit_req", a_ureq, 0);
        chk("R1 merge ack", m_ack, 0);
        chk("R1 merge unit_req", m_ureq, 0);
        rst = 1'b0;
        step();

        // Arbiter: every non-empty set of simultaneous requests
        for (int pat = 1; pat < 8; pat++) begin
            a_req = pat[2:0];
            done  = '0;
            for (int ch = 0; ch < 3; ch++) begin
                if (pat[ch]) begin
                    step();
                    chk("R7 grant edge, unit_req low", a_ureq, 0);
                    step();
                    chk("R6 unit_req for lowest waiting channel", a_ureq, 1);
                    chk("R6 acks before completion", a_ack, done);
                    a_uack = 1'b1;
                    step();
                    chk("R3 unit_req released", a_ureq, 0);
                    chk("R3 ack held low during unit ack", a_ack, done);
                    step();
                    chk("R3 unit_req stays low, controller holds req", a_ureq, 0);
                    chk("R3 ack still low", a_ack, done);
                    a_uack = 1'b0;
                    step();
                    done[ch] = 1'b1;
                    chk("R4 ack after unit return to zero", a_ack, done);
                    chk("R6 served channel order", a_ack, done);
                end
            end
            step();
            step();
            chk("R8 no refire while requests held", a_ureq, 0);
            chk("R5 acks held while requests held", a_ack, done);
            a_req = '0;
            step();
            chk("R5 acks fall after requests fall", a_ack, 0);
        end

        // Merge: one channel at a time
        for (int ch = 0; ch < 2; ch++) begin
            m_req = 2'(1 << ch);
            step();
            chk("R2 merge unit_req one edge", m_ureq, 1);
            m_uack = 1'b1;
            step();
            chk("R3 merge unit_req released", m_ureq, 0);
            chk("R3 merge ack low", m_ack, 0);
            m_uack = 1'b0;
            step();
            chk("R4 merge ack", m_ack, 1 << ch);
            step();
            chk("R8 merge no refire", m_ureq, 0);
            chk("R5 merge ack held", m_ack, 1 << ch);
            m_req = '0;
            step();
            chk("R5 merge ack falls", m_ack, 0);
        end

        // Stray unit acknowledge with no owner
        m_uack = 1'b1;
        a_uack = 1'b1;
        step();
        chk("R9 merge ack unaffected", m_ack, 0);
        chk("R9 merge unit_req unaffected", m_ureq, 0);
        chk("R9 arb ack unaffected", a_ack, 0);
        m_uack = 1'b0;
        a_uack = 1'b0;
        step();
        chk("R9 merge ack after pulse", m_ack, 0);
        chk("R9 arb unit_req after pulse", a_ureq, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule